// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 72 level-sensitive interrupt lines and presents them to a processor through a small 32-bit register port. The lines are split into three groups. The basic group has eight lines, numbered 0 to 7. Peripheral bank 1 has 32 lines, numbered 8 to 39. Peripheral bank 2 has 32 lines, numbered 40 to 71. Every line has an enable bit. Software never writes an enable mask directly. It sets bits through a write-one-to-set strobe register and clears them through a separate write-one-to-clear strobe register, so a write touches only the positions written as one.

Each peripheral bank has its own pending word. There is also a basic pending word. It carries the basic lines, one summary bit per bank, and shortcut copies of a few frequently used bank lines, so a handler can often decide which line fired with a single read. One interrupt output is high whenever any enabled line is pending. A further 32-bit register at offset 0x0C only stores what software writes. It has no effect on routing.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit is clear, the storage register at 0x0C is zero, `irq_out` is low, and every register reads zero.
- R2: A write to a set-strobe register (bank 1 at 0x10, bank 2 at 0x14, basic at 0x18) sets the enable of each bit written as one. Bits written as zero keep their value. For the basic group only write-data bits 7:0 are used.
- R3: A write to a clear-strobe register (bank 1 at 0x1C, bank 2 at 0x20, basic at 0x24) clears the enable of each bit written as one. Bits written as zero keep their value.
- R4: Reading the set-strobe or the clear-strobe register of a group returns that group's current enable mask. The basic mask reads in bits 7:0 and the upper bits read zero.
- R5: The bank pending words (bank 1 at 0x04, bank 2 at 0x08) read bit i as one exactly when line i of that bank was high at the previous clock edge and its enable bit is set. A source change appears one clock edge after it is applied.
- R6: Basic pending word (0x00) bits 7:0 are the enabled, registered basic lines.
- R7: Basic pending bit 8 is one when any bit of the bank 1 pending word is one. Bit 9 is one when any bit of the bank 2 pending word is one.
- R8: Basic pending bits 10, 11, 12, 13 and 14 copy bank 1 pending bits 7, 9, 10, 18 and 19, in that order.
- R9: Basic pending bits 15 to 20 copy bank 2 pending bits 21, 22, 23, 24, 25 and 30, in that order.
- R10: Basic pending bits 31:21 always read zero.
- R11: `irq_out` is the OR of every pending bit across the three groups.
- R12: The register at 0x0C stores all 32 written bits and reads them back. Writing it changes neither the enables nor `irq_out`.
- R13: Writes to the pending offsets or to unmapped offsets change no enable and no stored value. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register accessed |
| reg_we | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_basic | input | 8 | Basic interrupt lines 0 to 7 |
| src_bank1 | input | 32 | Bank 1 interrupt lines (numbers 8 to 39) |
| src_bank2 | input | 32 | Bank 2 interrupt lines (numbers 40 to 71) |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a pending bit that reads zero even though its line is high, because its enable was cleared. Reaching it also requires checking that the summary and shortcut bits drop along with it. The bench walks all 72 lines one at a time with everything enabled. For each line it then clears only that line's enable through the clear strobe, checks that every pending word and `irq_out` return to zero, and sets the enable again. Pseudo-random mixes of lines and enable masks then exercise the summary bits and shortcut copies with many lines active at once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int DATA_W  = 32;
  localparam int BASIC_N = 8;
  localparam int BANK_N  = 32;

  // byte offsets of the register map
  localparam int OFF_PEND_BASIC = 'h00;
  localparam int OFF_PEND_B1    = 'h04;
  localparam int OFF_PEND_B2    = 'h08;
  localparam int OFF_STORE      = 'h0C;
  localparam int OFF_SET_B1     = 'h10;
  localparam int OFF_SET_B2     = 'h14;
  localparam int OFF_SET_BASIC  = 'h18;
  localparam int OFF_CLR_B1     = 'h1C;
  localparam int OFF_CLR_B2     = 'h20;
  localparam int OFF_CLR_BASIC  = 'h24;

  // layout of the basic pending word
  localparam int SUM_B1_BIT  = BASIC_N;
  localparam int SUM_B2_BIT  = BASIC_N + 1;
  localparam int N_TAP1      = 5;
  localparam int N_TAP2      = 6;
  localparam int TAP1_BASE   = BASIC_N + 2;
  localparam int TAP2_BASE   = TAP1_BASE + N_TAP1;
  localparam int BASIC_USED  = TAP2_BASE + N_TAP2;

  localparam int TAP1_LINE [N_TAP1] = '{7, 9, 10, 18, 19};
  localparam int TAP2_LINE [N_TAP2] = '{21, 22, 23, 24, 25, 30};

  // Assemble the basic pending word from the three masked pending vectors.
  function automatic logic [DATA_W-1:0] basic_word(
    input logic [BASIC_N-1:0] p0,
    input logic [BANK_N-1:0]  p1,
    input logic [BANK_N-1:0]  p2
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[BASIC_N-1:0] = p0;
    w[SUM_B1_BIT]  = |p1;
    w[SUM_B2_BIT]  = |p2;
    for (int k = 0; k < N_TAP1; k++) w[TAP1_BASE + k] = p1[TAP1_LINE[k]];
    for (int k = 0; k < N_TAP2; k++) w[TAP2_BASE + k] = p2[TAP2_LINE[k]];
    return w;
  endfunction

  // Apply a set or clear strobe to an enable mask.
  function automatic logic [BANK_N-1:0] strobe_mask(
    input logic [BANK_N-1:0] cur,
    input logic [BANK_N-1:0] bits,
    input logic              set_op,
    input logic              clr_op
  );
    if (set_op)      return cur | bits;
    else if (clr_op) return cur & ~bits;
    else             return cur;
  endfunction

endpackage

// File: rtl/irqc_line_sync.sv
module irqc_line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_in,
  output logic [W-1:0] lines_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_in;
  end

endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg
  import irqc_pkg::*;
#(
  parameter int W = BANK_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] en_q
);

  logic [BANK_N-1:0] cur_w;
  logic [BANK_N-1:0] bits_w;
  logic [BANK_N-1:0] nxt_w;

  assign cur_w  = BANK_N'(en_q);
  assign bits_w = BANK_N'(bits);
  assign nxt_w  = strobe_mask(cur_w, bits_w, set_stb, clr_stb);

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= nxt_w[W-1:0];
  end

  generate
    if (W < BANK_N) begin : g_pad
      logic unused_hi;
      assign unused_hi = |nxt_w[BANK_N-1:W];
    end
  endgenerate

endmodule

// File: rtl/irqc_pend_core.sv
module irqc_pend_core
  import irqc_pkg::*;
(
  input  logic [BASIC_N-1:0] lvl_basic,
  input  logic [BANK_N-1:0]  lvl_b1,
  input  logic [BANK_N-1:0]  lvl_b2,
  input  logic [BASIC_N-1:0] en_basic,
  input  logic [BANK_N-1:0]  en_b1,
  input  logic [BANK_N-1:0]  en_b2,
  output logic [BASIC_N-1:0] pend_basic,
  output logic [BANK_N-1:0]  pend_b1,
  output logic [BANK_N-1:0]  pend_b2,
  output logic [DATA_W-1:0]  basic_status,
  output logic               irq
);

  assign pend_basic   = lvl_basic & en_basic;
  assign pend_b1      = lvl_b1 & en_b1;
  assign pend_b2      = lvl_b2 & en_b2;
  assign basic_status = basic_word(pend_basic, pend_b1, pend_b2);
  assign irq          = (|pend_basic) | (|pend_b1) | (|pend_b2);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [BASIC_N-1:0] src_basic,
  input  logic [BANK_N-1:0]  src_bank1,
  input  logic [BANK_N-1:0]  src_bank2,
  output logic              irq_out
);

  // address hits
  logic hit_set_b1, hit_set_b2, hit_set_basic;
  logic hit_clr_b1, hit_clr_b2, hit_clr_basic;
  logic hit_store;

  assign hit_set_b1    = reg_addr == ADDR_W'(OFF_SET_B1);
  assign hit_set_b2    = reg_addr == ADDR_W'(OFF_SET_B2);
  assign hit_set_basic = reg_addr == ADDR_W'(OFF_SET_BASIC);
  assign hit_clr_b1    = reg_addr == ADDR_W'(OFF_CLR_B1);
  assign hit_clr_b2    = reg_addr == ADDR_W'(OFF_CLR_B2);
  assign hit_clr_basic = reg_addr == ADDR_W'(OFF_CLR_BASIC);
  assign hit_store     = reg_addr == ADDR_W'(OFF_STORE);

  // named write events
  logic wr_set_b1, wr_set_b2, wr_set_basic;
  logic wr_clr_b1, wr_clr_b2, wr_clr_basic;
  logic wr_store;

  assign wr_set_b1    = reg_we & hit_set_b1;
  assign wr_set_b2    = reg_we & hit_set_b2;
  assign wr_set_basic = reg_we & hit_set_basic;
  assign wr_clr_b1    = reg_we & hit_clr_b1;
  assign wr_clr_b2    = reg_we & hit_clr_b2;
  assign wr_clr_basic = reg_we & hit_clr_basic;
  assign wr_store     = reg_we & hit_store;

  // registered source lines
  logic [BASIC_N-1:0] lvl_basic;
  logic [BANK_N-1:0]  lvl_b1;
  logic [BANK_N-1:0]  lvl_b2;

  irqc_line_sync #(.W(BASIC_N)) u_sync_basic (
    .clk(clk), .rst_n(rst_n), .lines_in(src_basic), .lines_q(lvl_basic));
  irqc_line_sync #(.W(BANK_N)) u_sync_b1 (
    .clk(clk), .rst_n(rst_n), .lines_in(src_bank1), .lines_q(lvl_b1));
  irqc_line_sync #(.W(BANK_N)) u_sync_b2 (
    .clk(clk), .rst_n(rst_n), .lines_in(src_bank2), .lines_q(lvl_b2));

  // enable masks
  logic [BASIC_N-1:0] en_basic;
  logic [BANK_N-1:0]  en_bank1;
  logic [BANK_N-1:0]  en_bank2;

  irqc_enable_reg #(.W(BASIC_N)) u_en_basic (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_set_basic), .clr_stb(wr_clr_basic),
    .bits(reg_wdata[BASIC_N-1:0]), .en_q(en_basic));
  irqc_enable_reg #(.W(BANK_N)) u_en_b1 (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_set_b1), .clr_stb(wr_clr_b1),
    .bits(reg_wdata[BANK_N-1:0]), .en_q(en_bank1));
  irqc_enable_reg #(.W(BANK_N)) u_en_b2 (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_set_b2), .clr_stb(wr_clr_b2),
    .bits(reg_wdata[BANK_N-1:0]), .en_q(en_bank2));

  // plain storage register
  logic [DATA_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        store_q <= '0;
    else if (wr_store) store_q <= reg_wdata;
  end

  // pending logic
  logic [BASIC_N-1:0] pend_basic;
  logic [BANK_N-1:0]  pend_bank1;
  logic [BANK_N-1:0]  pend_bank2;
  logic [DATA_W-1:0]  basic_status;

  irqc_pend_core u_core (
    .lvl_basic(lvl_basic), .lvl_b1(lvl_b1), .lvl_b2(lvl_b2),
    .en_basic(en_basic), .en_b1(en_bank1), .en_b2(en_bank2),
    .pend_basic(pend_basic), .pend_b1(pend_bank1), .pend_b2(pend_bank2),
    .basic_status(basic_status), .irq(irq_out));

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_PEND_BASIC))   reg_rdata = basic_status;
    else if (reg_addr == ADDR_W'(OFF_PEND_B1)) reg_rdata = DATA_W'(pend_bank1);
    else if (reg_addr == ADDR_W'(OFF_PEND_B2)) reg_rdata = DATA_W'(pend_bank2);
    else if (hit_store)                        reg_rdata = store_q;
    else if (hit_set_b1 | hit_clr_b1)          reg_rdata = DATA_W'(en_bank1);
    else if (hit_set_b2 | hit_clr_b2)          reg_rdata = DATA_W'(en_bank2);
    else if (hit_set_basic | hit_clr_basic)    reg_rdata = DATA_W'(en_basic);
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [BASIC_N-1:0] src_basic,
  input logic [BANK_N-1:0]  src_bank1,
  input logic [BANK_N-1:0]  src_bank2,
  input logic              irq_out,
  input logic [BASIC_N-1:0] en_basic,
  input logic [BANK_N-1:0]  en_bank1,
  input logic [BANK_N-1:0]  en_bank2,
  input logic [BANK_N-1:0]  pend_bank1,
  input logic [BANK_N-1:0]  pend_bank2
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic wr_b1_any;
  assign wr_b1_any = reg_we && (reg_addr == ADDR_W'(OFF_SET_B1) ||
                                reg_addr == ADDR_W'(OFF_CLR_B1));

  assert_set_b1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFF_SET_B1)) |=>
      en_bank1 == ($past(en_bank1) | $past(reg_wdata[BANK_N-1:0])));

  assert_clr_b1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFF_CLR_B1)) |=>
      en_bank1 == ($past(en_bank1) & ~$past(reg_wdata[BANK_N-1:0])));

  assert_hold_b1_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b1_any |=> $stable(en_bank1));

  assert_pend_b2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> pend_bank2 == ($past(src_bank2) & en_bank2));

  assert_irq_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> irq_out == ((|($past(src_basic) & en_basic)) |
                            (|($past(src_bank1) & en_bank1)) |
                            (|($past(src_bank2) & en_bank2))));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_PEND_BASIC)) |-> reg_rdata[DATA_W-1:BASIC_USED] == '0);

  assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_PEND_BASIC)) |->
      (reg_rdata[SUM_B1_BIT] == (|pend_bank1) && reg_rdata[SUM_B2_BIT] == (|pend_bank2)));

endmodule

bind irq_bank_ctrl irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_basic(src_basic),
  .src_bank1(src_bank1), .src_bank2(src_bank2), .irq_out(irq_out),
  .en_basic(en_basic), .en_bank1(en_bank1), .en_bank2(en_bank2),
  .pend_bank1(pend_bank1), .pend_bank2(pend_bank2));

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  s0;
  logic [31:0] s1, s2;
  logic        irq;

  irq_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .src_basic(s0), .src_bank1(s1), .src_bank2(s2),
    .irq_out(irq));

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model of the enables and the storage register
  logic [7:0]  m0;
  logic [31:0] m1, m2, mst;
  logic [31:0] lf = 32'h1ACE_5EED;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  task automatic drive(input logic [7:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk); s0 = a; s1 = b; s2 = c;
    @(negedge clk);
  endtask

  // model writes
  task automatic en_set(input int g, input logic [31:0] d);
    case (g)
      0: begin wr(8'h18, d); m0 = m0 | d[7:0]; end
      1: begin wr(8'h10, d); m1 = m1 | d; end
      default: begin wr(8'h14, d); m2 = m2 | d; end
    endcase
  endtask

  task automatic en_clr(input int g, input logic [31:0] d);
    case (g)
      0: begin wr(8'h24, d); m0 = m0 & ~d[7:0]; end
      1: begin wr(8'h1C, d); m1 = m1 & ~d; end
      default: begin wr(8'h20, d); m2 = m2 & ~d; end
    endcase
  endtask

  // expected basic pending word, written out bit by bit
  function automatic logic [31:0] exp_basic(input logic [7:0] p0,
                                            input logic [31:0] p1,
                                            input logic [31:0] p2);
    logic [31:0] r;
    r = 32'h0;
    r[7:0] = p0;
    r[8]  = (p1 != 0);
    r[9]  = (p2 != 0);
    r[10] = p1[7];  r[11] = p1[9];  r[12] = p1[10];
    r[13] = p1[18]; r[14] = p1[19];
    r[15] = p2[21]; r[16] = p2[22]; r[17] = p2[23];
    r[18] = p2[24]; r[19] = p2[25]; r[20] = p2[30];
    return r;
  endfunction

  task automatic check_status(input string tag);
    logic [31:0] d;
    logic [7:0]  p0;
    logic [31:0] p1, p2;
    p0 = s0 & m0; p1 = s1 & m1; p2 = s2 & m2;
    rd(8'h00, d); check({tag, " R6/R7/R8/R9/R10 basic pending"}, d, exp_basic(p0, p1, p2));
    rd(8'h04, d); check({tag, " R5 bank1 pending"}, d, p1);
    rd(8'h08, d); check({tag, " R5 bank2 pending"}, d, p2);
    check({tag, " R11 irq_out"}, {31'b0, irq},
          {31'b0, (p0 != 0) || (p1 != 0) || (p2 != 0)});
  endtask

  task automatic check_enables(input string tag);
    logic [31:0] d;
    rd(8'h10, d); check({tag, " R4 bank1 mask via set"}, d, m1);
    rd(8'h1C, d); check({tag, " R4 bank1 mask via clear"}, d, m1);
    rd(8'h14, d); check({tag, " R4 bank2 mask via set"}, d, m2);
    rd(8'h20, d); check({tag, " R4 bank2 mask via clear"}, d, m2);
    rd(8'h18, d); check({tag, " R4 basic mask via set"}, d, {24'b0, m0});
    rd(8'h24, d); check({tag, " R4 basic mask via clear"}, d, {24'b0, m0});
    rd(8'h0C, d); check({tag, " R12 storage"}, d, mst);
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  // watchdog
  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    s0 = '0; s1 = '0; s2 = '0;
    m0 = '0; m1 = '0; m2 = '0; mst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every register and the output
    check("R1 irq_out after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(8'(a), d);
      check("R1 register after reset", d, 32'h0);
    end

    // R2: set strobes accumulate, zeros leave bits alone
    en_set(1, 32'h0000_F00F);
    en_set(1, 32'h1230_0000);
    en_set(1, 32'h0);
    en_set(2, 32'h8000_0001);
    en_set(0, 32'hFFFF_FF5A);
    check_enables("R2 after sets");

    // R3: clear strobes remove only ones
    en_clr(1, 32'h0000_0F0F);
    en_clr(2, 32'h0000_0001);
    en_clr(0, 32'h0000_000A);
    en_clr(0, 32'h0);
    check_enables("R3 after clears");

    // R12: storage register round trip, no effect on enables or irq
    wr(8'h0C, 32'hA5A5_5A5A); mst = 32'hA5A5_5A5A;
    check_enables("R12 after storage write");
    check_status("R12 idle");

    // R13: writes to pending and unmapped offsets do nothing
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    check_enables("R13 after ignored writes");
    rd(8'h28, d); check("R13 unmapped read", d, 32'h0);
    rd(8'hFC, d); check("R13 unmapped read high", d, 32'h0);

    // enable everything
    en_set(0, 32'hFF); en_set(1, 32'hFFFF_FFFF); en_set(2, 32'hFFFF_FFFF);

    // R5: one-edge latency on a source change
    @(negedge clk); s1 = 32'h0000_0100; addr = 8'h04; #2;
    check("R5 not yet visible", rdata, 32'h0);
    check("R11 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk); #2;
    check("R5 visible after one edge", rdata, 32'h0000_0100);
    drive(8'h0, 32'h0, 32'h0);

    // walk all 72 lines, then mask each one alone
    for (int n = 0; n < 72; n++) begin
      int g;
      int b;
      logic [31:0] bit_v;
      g = (n < 8) ? 0 : (n < 40) ? 1 : 2;
      b = (n < 8) ? n : (n < 40) ? n - 8 : n - 40;
      bit_v = 32'h1 << b;
      drive((g == 0) ? bit_v[7:0] : 8'h0, (g == 1) ? bit_v : 32'h0,
            (g == 2) ? bit_v : 32'h0);
      check_status("walk enabled");
      en_clr(g, bit_v);
      check_status("walk masked R3");
      en_set(g, bit_v);
    end
    drive(8'h0, 32'h0, 32'h0);

    // R7/R8/R9: pseudo-random line and enable mixes
    for (int i = 0; i < 48; i++) begin
      logic [31:0] r0, r1, r2, r3, r4, r5;
      lf = step(lf); r0 = lf; lf = step(lf); r1 = lf; lf = step(lf); r2 = lf;
      lf = step(lf); r3 = lf; lf = step(lf); r4 = lf; lf = step(lf); r5 = lf;
      en_clr(0, 32'hFF); en_clr(1, 32'hFFFF_FFFF); en_clr(2, 32'hFFFF_FFFF);
      en_set(0, r3); en_set(1, r4 | r1);
      en_set(2, (i % 3 == 0) ? 32'h0 : r5);
      drive(r0[7:0], r1, r2);
      check_status("mix R7 R8 R9");
    end

    // R10: all lines high, everything enabled
    en_set(0, 32'hFF); en_set(1, 32'hFFFF_FFFF); en_set(2, 32'hFFFF_FFFF);
    drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R10 upper bits zero, all set", d, 32'h001F_FFFF);
    check_status("all high");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule